// File: doc/BRIEF.md
# Dual-Channel Interleaved Pixel Stream Assembler

This block sits behind a linear image sensor whose pixels leave on two video channels: one carries the even pixel positions and the other the odd positions. The two channels are clocked half a transfer period apart. After a lateral transfer, one `frame_go` pulse starts a readout frame. For each channel the block then produces two sample strobes per readout slot for correlated double sampling. The first strobe takes the reference level, once the reset pulse has ended and the output has settled. The second takes the signal level, once charge has arrived and the video has had time to settle. Each channel has its own ADC. The ADC returns each conversion with a one-cycle valid pulse.

At the end of every slot, the block subtracts the signal sample from the reference sample, clipping at zero. It then places the result into a single ordered stream that runs at twice the per-channel rate. Each output carries a 9-bit pixel index, start- and end-of-frame marks, and a flag for pixels whose samples did not arrive in time. The even channel's first slot carries only preload charge, with no photodiode behind it, and the block drops it. Slots beyond the per-channel count produce nothing.

Top module: `ilv_pixel_asm`

## Requirements
- R1: While `rst_n` is low and after its release with no `frame_go`, all strobes and all `px_*` outputs are 0.
- R2: On the even channel, slot k (k = 0..149) occupies cycles 1+8k to 8+8k after the cycle in which `frame_go` is high. `ev_rst_stb` is high in the third cycle of each slot (phase 2) and `ev_sig_stb` is high in the sixth (phase 5). Phase 7 is the slot's last cycle.
- R3: The odd channel follows the same slot pattern as the even channel, delayed by 4 cycles (half a slot).
- R4: Even slot 0 (position 0, preload only) is never emitted, so no output ever carries `px_idx` 0.
- R5: Even slot k maps to position 2k and odd slot k to 2k+1. The result appears on the cycle after the slot's last cycle. A full frame therefore yields indices 1 to 299, each one higher than the last, one every 4 cycles.
- R6: `px_val` is the reference sample minus the signal sample, or 0 when the signal sample is greater than or equal to the reference sample.
- R7: A valid pulse is taken as a channel's reference (or signal) sample only if it falls strictly after that strobe's cycle and before the slot's last cycle. Only the first such pulse counts. Pulses at any other time have no effect on the output.
- R8: If either sample of a slot was not taken, the output for that slot still appears, with `px_bad` = 1 and `px_val` = 0.
- R9: `px_sof` is high only with index 1, and `px_eof` is high only with index 299.
- R10: After slot 149 of both channels, no strobes and no pixels appear until the next `frame_go`.
- R11: A `frame_go` during a frame restarts both channels at slot 0 and discards the partially collected samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Starts a readout frame |
| ev_adc_vld | input | 1 | Even ADC sample valid |
| ev_adc_dat | input | 12 | Even ADC sample |
| od_adc_vld | input | 1 | Odd ADC sample valid |
| od_adc_dat | input | 12 | Odd ADC sample |
| ev_rst_stb | output | 1 | Even reference-level strobe |
| ev_sig_stb | output | 1 | Even signal-level strobe |
| od_rst_stb | output | 1 | Odd reference-level strobe |
| od_sig_stb | output | 1 | Odd signal-level strobe |
| px_vld | output | 1 | Output pixel valid |
| px_idx | output | 9 | Pixel position |
| px_val | output | 12 | Reference minus signal, clipped at zero |
| px_bad | output | 1 | A sample was missing for this pixel |
| px_sof | output | 1 | First pixel of frame |
| px_eof | output | 1 | Last pixel of frame |

## Verification
The hardest case to reach is a sample that arrives exactly on the slot's last cycle. It looks valid, but it must be ignored, so the slot has to be flagged bad. The bench reaches it by delaying selected signal replies by two cycles so that they land on that edge. Other replies are withheld, duplicated, or sent while no strobe is pending. A restart partway through a frame, placed where no emission is in flight, checks that stale samples are dropped.

// File: rtl/pxa_pkg.sv
package pxa_pkg;

  typedef enum logic {
    CH_EVEN = 1'b0,
    CH_ODD  = 1'b1
  } chan_e;

  // Reference level minus signal level, floored at zero.
  function automatic int unsigned cds_level(input int unsigned lvl_rst, input int unsigned lvl_sig);
    return (lvl_rst > lvl_sig) ? lvl_rst - lvl_sig : 0;
  endfunction

  // Sensor position of a readout slot on a given channel.
  function automatic int unsigned pixel_pos(input chan_e ch, input int unsigned slot);
    return 2 * slot + ((ch == CH_ODD) ? 1 : 0);
  endfunction

endpackage

// File: rtl/pxa_chan_seq.sv
module pxa_chan_seq
  import pxa_pkg::*;
#(
  parameter int SLOT_CYC = 8,
  parameter int REF_AT   = 2,
  parameter int SIG_AT   = 5,
  parameter int LAG      = 0,
  parameter int SLOTS    = 150,
  parameter int DW       = 12,
  localparam int PW      = $clog2(SLOT_CYC) + 1,
  localparam int SW      = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          adc_vld,
  input  logic [DW-1:0] adc_dat,
  output logic          rst_stb,
  output logic          sig_stb,
  output logic          emit,
  output logic [SW-1:0] emit_slot,
  output logic          emit_ok,
  output logic [DW-1:0] emit_pix
);

  logic          run;
  logic [PW-1:0] hold;
  logic [PW-1:0] ph;
  logic [SW-1:0] slot;
  logic          rst_wait, sig_wait, rst_ok, sig_ok;
  logic [DW-1:0] rst_q, sig_q;
  logic          live;
  logic          last_ph;

  assign live      = run && (hold == '0);
  assign last_ph   = (ph == PW'(SLOT_CYC - 1));
  assign rst_stb   = live && (ph == PW'(REF_AT));
  assign sig_stb   = live && (ph == PW'(SIG_AT));
  assign emit      = live && last_ph;
  assign emit_slot = slot;
  assign emit_ok   = rst_ok && sig_ok;
  assign emit_pix  = emit_ok ? DW'(cds_level(32'(rst_q), 32'(sig_q))) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      hold     <= '0;
      ph       <= '0;
      slot     <= '0;
      rst_wait <= 1'b0;
      sig_wait <= 1'b0;
      rst_ok   <= 1'b0;
      sig_ok   <= 1'b0;
      rst_q    <= '0;
      sig_q    <= '0;
    end else if (go) begin
      run      <= 1'b1;
      hold     <= PW'(LAG);
      ph       <= '0;
      slot     <= '0;
      rst_wait <= 1'b0;
      sig_wait <= 1'b0;
      rst_ok   <= 1'b0;
      sig_ok   <= 1'b0;
    end else begin
      if (run) begin
        if (hold != '0) begin
          hold <= hold - 1'b1;
        end else if (last_ph) begin
          ph   <= '0;
          slot <= slot + 1'b1;
          if (slot == SW'(SLOTS - 1)) run <= 1'b0;
        end else begin
          ph <= ph + 1'b1;
        end
      end
      if (rst_stb) begin
        rst_wait <= 1'b1;
        rst_ok   <= 1'b0;
      end else if (rst_wait && adc_vld) begin
        rst_q    <= adc_dat;
        rst_ok   <= 1'b1;
        rst_wait <= 1'b0;
      end
      if (sig_stb) begin
        sig_wait <= 1'b1;
        sig_ok   <= 1'b0;
      end else if (sig_wait && adc_vld) begin
        sig_q    <= adc_dat;
        sig_ok   <= 1'b1;
        sig_wait <= 1'b0;
      end
      if (emit) begin
        rst_wait <= 1'b0;
        sig_wait <= 1'b0;
        rst_ok   <= 1'b0;
        sig_ok   <= 1'b0;
      end
    end
  end

  // R7: a reference sample is only taken while it is awaited and a valid pulse is present
  p_take_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_ok) |-> $past(rst_wait) && $past(adc_vld));

  // R8: slot results never carry over into the next slot
  p_ok_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> !rst_ok && !sig_ok);

  // R10: the slot counter stays inside the frame while running
  p_slot_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> slot < SW'(SLOTS));

endmodule

// File: rtl/pxa_merge.sv
module pxa_merge #(
  parameter int DW    = 12,
  parameter int SW    = 8,
  parameter int SLOTS = 150,
  localparam int IW   = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_emit,
  input  logic [SW-1:0] ev_slot,
  input  logic          ev_ok,
  input  logic [DW-1:0] ev_pix,
  input  logic          od_emit,
  input  logic [SW-1:0] od_slot,
  input  logic          od_ok,
  input  logic [DW-1:0] od_pix,
  output logic          px_vld,
  output logic [IW-1:0] px_idx,
  output logic [DW-1:0] px_val,
  output logic          px_bad,
  output logic          px_sof,
  output logic          px_eof
);

  logic          take;
  logic          ev_take;
  logic [IW-1:0] nidx;
  logic          nok;
  logic [DW-1:0] npix;
  logic [IW-1:0] prev_idx;

  // Even slot 0 holds preload only and is dropped here.
  assign ev_take = ev_emit && (ev_slot != '0);

  always_comb begin
    take = 1'b0;
    nidx = '0;
    nok  = 1'b0;
    npix = '0;
    if (ev_take) begin
      take = 1'b1;
      nidx = {ev_slot, 1'b0};
      nok  = ev_ok;
      npix = ev_pix;
    end else if (od_emit) begin
      take = 1'b1;
      nidx = {od_slot, 1'b1};
      nok  = od_ok;
      npix = od_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_vld   <= 1'b0;
      px_idx   <= '0;
      px_val   <= '0;
      px_bad   <= 1'b0;
      px_sof   <= 1'b0;
      px_eof   <= 1'b0;
      prev_idx <= '0;
    end else begin
      px_vld <= take;
      px_sof <= take && (nidx == IW'(1));
      px_eof <= take && (nidx == IW'(2 * SLOTS - 1));
      px_bad <= take && !nok;
      if (take) begin
        prev_idx <= px_idx;
        px_idx   <= nidx;
        px_val   <= npix;
      end
    end
  end

  // R5: the two channels never finish a slot in the same cycle
  p_no_collide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_emit && od_emit));

  // R5: within a frame each index is one above the previous
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld && !px_sof |-> px_idx == prev_idx + 1'b1);

  // R4: the preload position never reaches the output
  p_idx_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld |-> px_idx != '0);

  // R8: a flagged pixel carries a zero value
  p_bad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    px_vld && px_bad |-> px_val == '0);

  // R9: the end-of-frame pixel is followed by a gap
  p_eof_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    px_eof |=> !px_vld);

endmodule

// File: rtl/ilv_pixel_asm.sv
module ilv_pixel_asm #(
  parameter int SLOT_CYC = 8,
  parameter int REF_AT   = 2,
  parameter int SIG_AT   = 5,
  parameter int SLOTS    = 150,
  parameter int DW       = 12,
  localparam int SW      = $clog2(SLOTS + 1),
  localparam int IW      = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_go,
  input  logic          ev_adc_vld,
  input  logic [DW-1:0] ev_adc_dat,
  input  logic          od_adc_vld,
  input  logic [DW-1:0] od_adc_dat,
  output logic          ev_rst_stb,
  output logic          ev_sig_stb,
  output logic          od_rst_stb,
  output logic          od_sig_stb,
  output logic          px_vld,
  output logic [IW-1:0] px_idx,
  output logic [DW-1:0] px_val,
  output logic          px_bad,
  output logic          px_sof,
  output logic          px_eof
);

  localparam int HALF = SLOT_CYC / 2;

  logic [1:0]    vld_a;
  logic [DW-1:0] dat_a  [2];
  logic [1:0]    rstb_a, sstb_a, emit_a, ok_a;
  logic [SW-1:0] slot_a [2];
  logic [DW-1:0] pix_a  [2];

  assign vld_a[0] = ev_adc_vld;
  assign vld_a[1] = od_adc_vld;
  assign dat_a[0] = ev_adc_dat;
  assign dat_a[1] = od_adc_dat;

  for (genvar g = 0; g < 2; g++) begin : g_chan
    pxa_chan_seq #(
      .SLOT_CYC(SLOT_CYC),
      .REF_AT  (REF_AT),
      .SIG_AT  (SIG_AT),
      .LAG     (g * HALF),
      .SLOTS   (SLOTS),
      .DW      (DW)
    ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (frame_go),
      .adc_vld  (vld_a[g]),
      .adc_dat  (dat_a[g]),
      .rst_stb  (rstb_a[g]),
      .sig_stb  (sstb_a[g]),
      .emit     (emit_a[g]),
      .emit_slot(slot_a[g]),
      .emit_ok  (ok_a[g]),
      .emit_pix (pix_a[g])
    );
  end

  assign ev_rst_stb = rstb_a[0];
  assign ev_sig_stb = sstb_a[0];
  assign od_rst_stb = rstb_a[1];
  assign od_sig_stb = sstb_a[1];

  pxa_merge #(
    .DW   (DW),
    .SW   (SW),
    .SLOTS(SLOTS)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_emit(emit_a[0]),
    .ev_slot(slot_a[0]),
    .ev_ok  (ok_a[0]),
    .ev_pix (pix_a[0]),
    .od_emit(emit_a[1]),
    .od_slot(slot_a[1]),
    .od_ok  (ok_a[1]),
    .od_pix (pix_a[1]),
    .px_vld (px_vld),
    .px_idx (px_idx),
    .px_val (px_val),
    .px_bad (px_bad),
    .px_sof (px_sof),
    .px_eof (px_eof)
  );

  // R3: the odd reference strobe never coincides with the even one
  p_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rst_stb |-> !od_rst_stb);

endmodule

// File: tb/ilv_pixel_asm_test.sv
module ilv_pixel_asm_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_go = 1'b0;
  logic ev_adc_vld = 1'b0, od_adc_vld = 1'b0;
  logic [11:0] ev_adc_dat = '0, od_adc_dat = '0;
  logic ev_rst_stb, ev_sig_stb, od_rst_stb, od_sig_stb;
  logic px_vld, px_bad, px_sof, px_eof;
  logic [8:0] px_idx;
  logic [11:0] px_val;

  always #10 clk = ~clk;

  ilv_pixel_asm uut (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go),
    .ev_adc_vld(ev_adc_vld), .ev_adc_dat(ev_adc_dat),
    .od_adc_vld(od_adc_vld), .od_adc_dat(od_adc_dat),
    .ev_rst_stb(ev_rst_stb), .ev_sig_stb(ev_sig_stb),
    .od_rst_stb(od_rst_stb), .od_sig_stb(od_sig_stb),
    .px_vld(px_vld), .px_idx(px_idx), .px_val(px_val),
    .px_bad(px_bad), .px_sof(px_sof), .px_eof(px_eof)
  );

  int total = 0, bad = 0, n = 0, pol = 0, frm = 0;
  // reference model
  bit m_act = 0; int m_t = 0;
  bit rw[2], sw[2], rok[2], sok[2]; int rq[2], sq[2];
  bit e_vld = 0, e_bad = 0, e_sof = 0, e_eof = 0; int e_idx = 0, e_val = 0;
  // reply schedule
  int ra[2] = '{-1, -1}, sa[2] = '{-1, -1}, da[2] = '{-1, -1};
  int rv[2], sv[2];
  // frame tallies
  int f_pix = 0, f_sof = 0, f_eof = 0, f_bad = 0, f_idx0 = 0, f_zero = 0, f_stb = 0;
  int m_bad = 0, m_sat = 0, junk_sent = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, n);
    end
  endtask

  function automatic int clip(input int a, input int b);
    int d = a - b;
    if (d < 0) d = 0;
    return d;
  endfunction

  function automatic int rval(input int c, input int s);
    return 2000 + ((s * 37 + c * 11 + frm * 5) % 1000);
  endfunction
  function automatic int sval(input int c, input int s);
    return (s * 53 + c * 29 + frm * 17) % 3500;
  endfunction

  task automatic step(input bit go);
    bit lv[2], er[2], es[2], ee[2]; int ph[2], sl[2];
    bit vl[2]; int dt[2];
    bit nv; int ni, nval; bit nb;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      int o = c * 4;
      lv[c] = m_act && (m_t >= o) && ((m_t - o) / 8 < 150);
      ph[c] = lv[c] ? (m_t - o) % 8 : 0;
      sl[c] = lv[c] ? (m_t - o) / 8 : 0;
      er[c] = lv[c] && ph[c] == 2;
      es[c] = lv[c] && ph[c] == 5;
      ee[c] = lv[c] && ph[c] == 7;
    end
    chk({ev_rst_stb, ev_sig_stb} == {er[0], es[0]}, "R2 even strobes", {ev_rst_stb, ev_sig_stb}, {er[0], es[0]});
    chk({od_rst_stb, od_sig_stb} == {er[1], es[1]}, "R3 odd strobes", {od_rst_stb, od_sig_stb}, {er[1], es[1]});
    f_stb += ev_rst_stb + ev_sig_stb + od_rst_stb + od_sig_stb;
    chk(px_vld == e_vld, "R5 pixel timing", px_vld, e_vld);
    if (e_vld && px_vld) begin
      chk(px_idx == e_idx, "R5 index", px_idx, e_idx);
      chk(px_bad == e_bad, "R8 missing flag", px_bad, e_bad);
      chk(px_val == e_val, "R6 value", px_val, e_val);
      chk({px_sof, px_eof} == {e_sof, e_eof}, "R9 frame marks", {px_sof, px_eof}, {e_sof, e_eof});
    end
    if (px_vld) begin
      f_pix++; f_sof += px_sof; f_eof += px_eof; f_bad += px_bad;
      if (px_idx == 0) f_idx0++;
      if (!px_bad && px_val == 0) f_zero++;
    end
    // drive inputs for this cycle
    frame_go = go;
    for (int c = 0; c < 2; c++) begin
      vl[c] = 0; dt[c] = 0;
      if (ra[c] == n) begin vl[c] = 1; dt[c] = rv[c]; end
      else if (sa[c] == n) begin vl[c] = 1; dt[c] = sv[c]; end
      else if (da[c] == n) begin vl[c] = 1; dt[c] = 12'hFFF; end
      else if (pol == 3 && lv[c] && ph[c] == 0) begin vl[c] = 1; dt[c] = 12'h5A5; junk_sent++; end
    end
    ev_adc_vld = vl[0]; ev_adc_dat = 12'(dt[0]);
    od_adc_vld = vl[1]; od_adc_dat = 12'(dt[1]);
    // schedule replies
    for (int c = 0; c < 2; c++) begin
      if (er[c]) begin
        if (pol == 2 && sl[c] % 7 == 1) ra[c] = -1;
        else ra[c] = n + ((pol == 1) ? 3 : 1);
        rv[c] = rval(c, sl[c]);
        if (pol == 3) da[c] = n + 2;
      end
      if (es[c]) begin
        sa[c] = n + ((pol == 2 && sl[c] % 5 == 3) ? 2 : 1);
        sv[c] = sval(c, sl[c]);
      end
    end
    // advance model through the next edge
    nv = 0; ni = 0; nval = 0; nb = 0;
    for (int c = 0; c < 2; c++) begin
      if (ee[c]) begin
        bit ok = rok[c] && sok[c];
        if (!(c == 0 && sl[c] == 0)) begin
          nv = 1; ni = 2 * sl[c] + c; nb = !ok;
          nval = ok ? clip(rq[c], sq[c]) : 0;
          if (!ok) m_bad++;
          else if (sq[c] >= rq[c]) m_sat++;
        end
      end
      if (!go) begin
        if (er[c]) begin rw[c] = 1; rok[c] = 0; end
        else if (rw[c] && vl[c]) begin rq[c] = dt[c]; rok[c] = 1; rw[c] = 0; end
        if (es[c]) begin sw[c] = 1; sok[c] = 0; end
        else if (sw[c] && vl[c]) begin sq[c] = dt[c]; sok[c] = 1; sw[c] = 0; end
        if (ee[c]) begin rw[c] = 0; sw[c] = 0; rok[c] = 0; sok[c] = 0; end
      end else begin
        rw[c] = 0; sw[c] = 0; rok[c] = 0; sok[c] = 0;
      end
    end
    e_vld = nv; e_idx = ni; e_val = nval; e_bad = nb;
    e_sof = nv && ni == 1; e_eof = nv && ni == 299;
    if (go) begin m_act = 1; m_t = 0; end
    else if (m_act) m_t++;
    n++;
  endtask

  task automatic clear_tally();
    f_pix = 0; f_sof = 0; f_eof = 0; f_bad = 0; f_idx0 = 0; f_zero = 0;
    m_bad = 0; m_sat = 0; junk_sent = 0;
  endtask

  task automatic run_frame(input int p);
    pol = p; frm++;
    step(1);
    clear_tally();
    repeat (1215) step(0);
    chk(f_pix == 299, "R5 pixels per frame", f_pix, 299);
    chk(f_sof == 1 && f_eof == 1, "R9 one sof and one eof", f_sof * 10 + f_eof, 11);
    chk(f_idx0 == 0, "R4 preload slot dropped", f_idx0, 0);
    chk(f_bad == m_bad, "R8 missing count", f_bad, m_bad);
    f_stb = 0;
    repeat (60) step(0);
    chk(f_stb == 0, "R10 quiet after frame strobes", f_stb, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk({px_vld, px_sof, px_eof, px_bad, ev_rst_stb, od_rst_stb} == 0, "R1 reset outputs",
        {px_vld, px_sof, px_eof, px_bad, ev_rst_stb, od_rst_stb}, 0);
    rst_n = 1'b1;
    repeat (20) step(0);
    chk(f_stb == 0 && f_pix == 0, "R1 idle before first frame", f_stb + f_pix, 0);
    run_frame(0);
    chk(m_sat > 0 && f_zero >= m_sat, "R6 clipped pixels seen", f_zero, m_sat);
    run_frame(1);
    run_frame(2);
    chk(m_bad > 0, "R8 missing pixels exercised", m_bad, 1);
    run_frame(3);
    chk(junk_sent > 0 && f_bad == 0, "R7 stray pulses ignored", f_bad, 0);
    // R11: restart mid-frame at a cycle without an emission in flight
    pol = 0; frm++;
    step(1);
    repeat (500) step(0);
    run_frame(0);
    chk(f_bad == 0, "R11 restart leaves no stale flags", f_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R5 watchdog: cycles=%0d expected<%0d", 150000, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule